// File: doc/BRIEF.md
# Dual-Read Register Bank Slice

This block is a small bank of eight storage locations with one write port and two read ports that work at the same time. On each rising clock edge the write data is committed into the location named by the write address. Two read addresses pick, independently of each other and of the write address, which locations appear on the two read outputs.

The read outputs come from output latches, not straight from the storage. Each output latch is open while the clock is HIGH and closed while it is LOW. A read of the location that is being written therefore shows the old content until the edge, and the new content once the clock is HIGH. An active-low bypass input holds both output latches open whatever the clock level. The word width is a parameter, so one instance serves any number of bit slices that share addresses and clock.

Top module: `drb_regbank`

## Requirements
- R1: While `rst_n` is low, every location holds zero, and a read of any location during a clock-HIGH phase returns zero on both outputs.
- R2: On each rising clock edge outside reset, `wr_data` is stored in the location numbered `wr_addr` (binary, 0 to 7).
- R3: A rising edge changes no location other than the one numbered `wr_addr`.
- R4: While the clock is HIGH, `rd_data_b` equals the content of the location numbered `rd_addr_b`.
- R5: While the clock is HIGH, `rd_data_c` equals the content of the location numbered `rd_addr_c`, independently of port B.
- R6: Both read ports may name the same location, or different ones, in any of the 64 combinations.
- R7: With `follow_n` high and the clock LOW, both outputs hold the value they had at the falling edge, even when the read addresses change.
- R8: When a read port names the location being written, it shows the old content during the LOW phase before the edge and the new content during the HIGH phase after it.
- R9: With `follow_n` low, both outputs track their read addresses during the clock-LOW phase as well.
- R10: With `follow_n` low, a change of `wr_addr` or `wr_data` during the LOW phase does not reach the outputs before the next rising edge.
- R11: Each bit of a word is stored and read independently, so bit i of every output comes from bit i of the addressed location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge, output latches open while HIGH |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| follow_n | input | 1 | Active-low bypass holding both output latches open |
| wr_addr | input | 3 | Location written at the next rising edge |
| wr_data | input | W | Data written |
| rd_addr_b | input | 3 | Location read on port B |
| rd_addr_c | input | 3 | Location read on port C |
| rd_data_b | output | W | Port B read data |
| rd_data_c | output | W | Port C read data |

## Verification
The bench builds the bank with W = 4 and the eight locations, so every location can carry a distinct non-zero value and all 64 read-address pairs are swept in full. The four-bit width lets complementary bit patterns expose any crossing between bit lanes, and a written value can always differ from the old one in every bit, which makes the old-versus-new behaviour around a same-location write visible on each bit.

// File: rtl/drb_pkg.sv
package drb_pkg;
  localparam int unsigned DRB_LOCS  = 8;
  localparam int unsigned DRB_PORTS = 2;
endpackage

// File: rtl/drb_wdec.sv
module drb_wdec #(
  parameter int unsigned LOCS = 8,
  parameter int unsigned AW   = $clog2(LOCS)
) (
  input  logic [AW-1:0]   addr,
  output logic [LOCS-1:0] sel
);
  always_comb begin
    for (int i = 0; i < LOCS; i++) begin
      sel[i] = (addr == AW'(i));
    end
  end
endmodule

// File: rtl/drb_bank.sv
module drb_bank #(
  parameter int unsigned W    = 1,
  parameter int unsigned LOCS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LOCS-1:0]         we,
  input  logic [W-1:0]            din,
  output logic [LOCS-1:0][W-1:0]  store
);
  for (genvar i = 0; i < LOCS; i++) begin : g_loc
    logic [W-1:0] loc_d;
    logic         loc_en;

    always_comb begin
      loc_en = we[i];
      loc_d  = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store[i] <= '0;
      end else if (loc_en) begin
        store[i] <= loc_d;
      end
    end
  end
endmodule

// File: rtl/drb_rdport.sv
module drb_rdport #(
  parameter int unsigned W    = 1,
  parameter int unsigned LOCS = 8,
  parameter int unsigned AW   = $clog2(LOCS)
) (
  input  logic                   open,
  input  logic [AW-1:0]          addr,
  input  logic [LOCS-1:0][W-1:0] store,
  output logic [W-1:0]           q
);
  logic [W-1:0] sel_data;

  always_comb begin
    sel_data = store[addr];
  end

  always_latch begin
    if (open) begin
      q <= sel_data;
    end
  end
endmodule

// File: rtl/drb_regbank.sv
module drb_regbank
  import drb_pkg::*;
#(
  parameter int unsigned W    = 1,
  parameter int unsigned LOCS = DRB_LOCS,
  parameter int unsigned AW   = $clog2(LOCS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          follow_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr_b,
  input  logic [AW-1:0] rd_addr_c,
  output logic [W-1:0]  rd_data_b,
  output logic [W-1:0]  rd_data_c
);
  localparam int unsigned NPORT = DRB_PORTS;

  // reset: asserted at once, released after two rising edges
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [LOCS-1:0]         wr_sel;
  logic [LOCS-1:0][W-1:0]  store;
  logic                    slave_open;
  logic [NPORT-1:0][AW-1:0] rd_addr_v;
  logic [NPORT-1:0][W-1:0]  rd_data_v;

  drb_wdec #(.LOCS(LOCS), .AW(AW)) u_wdec (
    .addr (wr_addr),
    .sel  (wr_sel)
  );

  drb_bank #(.W(W), .LOCS(LOCS)) u_bank (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (wr_sel),
    .din   (wr_data),
    .store (store)
  );

  always_comb begin
    slave_open   = clk | ~follow_n;
    rd_addr_v[0] = rd_addr_b;
    rd_addr_v[1] = rd_addr_c;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    drb_rdport #(.W(W), .LOCS(LOCS), .AW(AW)) u_rd (
      .open  (slave_open),
      .addr  (rd_addr_v[p]),
      .store (store),
      .q     (rd_data_v[p])
    );
  end

  always_comb begin
    rd_data_b = rd_data_v[0];
    rd_data_c = rd_data_v[1];
  end
endmodule

// File: rtl/drb_regbank_chk.sv
module drb_regbank_chk #(
  parameter int unsigned W    = 1,
  parameter int unsigned LOCS = 8,
  parameter int unsigned AW   = $clog2(LOCS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   follow_n,
  input logic [AW-1:0]          wr_addr,
  input logic [W-1:0]           wr_data,
  input logic [AW-1:0]          rd_addr_b,
  input logic [AW-1:0]          rd_addr_c,
  input logic [W-1:0]           rd_data_b,
  input logic [W-1:0]           rd_data_c,
  input logic [LOCS-1:0]        we,
  input logic [LOCS-1:0][W-1:0] store
);
  logic [W-1:0] neg_b;
  logic [W-1:0] neg_c;
  logic         neg_follow_n;
  logic         neg_seen;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_b        <= '0;
      neg_c        <= '0;
      neg_follow_n <= 1'b0;
      neg_seen     <= 1'b0;
    end else begin
      neg_b        <= rd_data_b;
      neg_c        <= rd_data_c;
      neg_follow_n <= follow_n;
      neg_seen     <= 1'b1;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> store[$past(wr_addr)] == $past(wr_data)); // R2

  for (genvar i = 0; i < LOCS; i++) begin : g_keep
    AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(store[i])); // R3
  end

  AST_HIGH_FOLLOW_B: assert property (@(negedge clk) disable iff (!rst_n)
    rd_data_b == store[rd_addr_b]); // R4

  AST_HIGH_FOLLOW_C: assert property (@(negedge clk) disable iff (!rst_n)
    rd_data_c == store[rd_addr_c]); // R5

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_seen && follow_n && neg_follow_n) |-> (rd_data_b == neg_b && rd_data_c == neg_c)); // R7

  AST_BYPASS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !follow_n |-> (rd_data_b == store[rd_addr_b] && rd_data_c == store[rd_addr_c])); // R9
endmodule

bind drb_regbank drb_regbank_chk #(.W(W), .LOCS(LOCS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .follow_n  (follow_n),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr_b (rd_addr_b),
  .rd_addr_c (rd_addr_c),
  .rd_data_b (rd_data_b),
  .rd_data_c (rd_data_c),
  .we        (wr_sel),
  .store     (store)
);

// File: tb/drb_regbank_bench.sv
module drb_regbank_bench;
  localparam int CLK_P = 20;
  localparam int W     = 4;
  localparam int AW    = 3;

  logic          clk;
  logic          rst_n;
  logic          follow_n;
  logic [AW-1:0] wr_addr;
  logic [W-1:0]  wr_data;
  logic [AW-1:0] rd_addr_b;
  logic [AW-1:0] rd_addr_c;
  logic [W-1:0]  rd_data_b;
  logic [W-1:0]  rd_data_c;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] model [8];

  drb_regbank #(.W(W)) u_drb_regbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .follow_n  (follow_n),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_b (rd_addr_b),
    .rd_addr_c (rd_addr_c),
    .rd_data_b (rd_data_b),
    .rd_data_c (rd_data_c)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  // every rising edge writes wr_data into wr_addr (R2)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) model[i] = '0;
    end else begin
      model[wr_addr] = wr_data;
    end
  end

  function automatic logic [W-1:0] pat(int a);
    return W'((a * 5 + 3) % 16);
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk);
    #1 wr_addr = AW'(a);
    wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [W-1:0] eb, ec, oldv, newv;
    rst_n = 1'b0; follow_n = 1'b1;
    wr_addr = '0; wr_data = '0; rd_addr_b = '0; rd_addr_c = '0;

    // R1: reset state, both ports, every location
    repeat (2) @(posedge clk);
    for (int a = 0; a < 8; a++) begin
      @(posedge clk);
      #2 rd_addr_b = AW'(a); rd_addr_c = AW'(7 - a);
      #2 chk("R1 port B", rd_data_b, '0);
      chk("R1 port C", rd_data_c, '0);
    end
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: fill every location
    for (int a = 0; a < 8; a++) wr(a, pat(a));

    // R4 R5 R6: all 64 read-address pairs in HIGH phases
    for (int b = 0; b < 8; b++) begin
      for (int c = 0; c < 8; c++) begin
        @(posedge clk);
        #2 rd_addr_b = AW'(b); rd_addr_c = AW'(c);
        #2 chk("R4 R6 port B", rd_data_b, pat(b));
        chk("R5 R6 port C", rd_data_c, pat(c));
      end
    end

    // R3: overwrite location 2, others keep their pattern
    wr(2, 4'hF);
    wr(2, 4'hF);
    for (int a = 0; a < 8; a++) begin
      @(posedge clk);
      #2 rd_addr_b = AW'(a); rd_addr_c = 3'd2;
      #2 chk("R3 port B", rd_data_b, (a == 2) ? 4'hF : pat(a));
      chk("R2 port C", rd_data_c, 4'hF);
    end

    // R7: hold through LOW phase while addresses move
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #2 rd_addr_b = AW'(k); rd_addr_c = AW'(k + 4);
      eb = model[k]; ec = model[k + 4];
      @(negedge clk);
      #2 rd_addr_b = AW'((k + 2) % 8); rd_addr_c = AW'(k ^ 5);
      #3 chk("R7 port B", rd_data_b, eb);
      chk("R7 port C", rd_data_c, ec);
    end

    // R8: same-location write and read
    @(posedge clk);
    #2 rd_addr_b = 3'd5; rd_addr_c = 3'd5;
    oldv = model[5]; newv = ~oldv;
    @(negedge clk);
    #2 wr_addr = 3'd5; wr_data = newv;
    #2 chk("R8 old B", rd_data_b, oldv);
    chk("R8 old C", rd_data_c, oldv);
    @(posedge clk);
    #2 chk("R8 new B", rd_data_b, newv);
    chk("R8 new C", rd_data_c, newv);

    // R9: bypass low, outputs track addresses during LOW phase
    @(negedge clk);
    #1 follow_n = 1'b0;
    for (int a = 0; a < 8; a++) begin
      rd_addr_b = AW'(a); rd_addr_c = AW'(7 - a);
      #1 chk("R9 port B", rd_data_b, model[a]);
      chk("R9 port C", rd_data_c, model[7 - a]);
    end

    // R10: uncommitted write stays invisible until the edge
    @(negedge clk);
    #1 oldv = model[3]; newv = oldv ^ 4'h9;
    rd_addr_b = 3'd3; wr_addr = 3'd3; wr_data = newv;
    #2 chk("R10 before edge", rd_data_b, oldv);
    @(posedge clk);
    #2 chk("R10 after edge", rd_data_b, newv);
    #1 follow_n = 1'b1;

    // R11: complementary bit lanes
    wr(0, 4'b1010);
    wr(1, 4'b0101);
    @(posedge clk);
    #2 rd_addr_b = 3'd0; rd_addr_c = 3'd1;
    #2;
    for (int j = 0; j < W; j++) begin
      chk("R11 lane B", W'(rd_data_b[j]), W'(j % 2));
      chk("R11 lane C", W'(rd_data_c[j]), W'((j + 1) % 2));
    end

    finish_up();
  end
endmodule